// File: doc/BRIEF.md
# Per-Pin GPIO Control Register Bank

This block is a memory-mapped GPIO controller in which every pin owns a single 32-bit control word. That word holds all of the pin's attributes: the driven level, the drive enable, interrupt enable and trigger type, reset tolerance, debounce selects and input masking. The same word also reports the pin's latched interrupt status, which is cleared by writing one, and its sampled input level. Three debounce time words and one interrupt summary word per group of 32 pins fill out the map. The block has a single combined interrupt line.

Software reaches the block through a simple 32-bit register port, and each access takes one cycle. The external pins come in through a synchronizer and feed the edge and level detectors. Each pin has two build-time capability bits, input-capable and output-capable, and these force what the pin may store. A write to a control word that sets any reserved bit is dropped as a whole.

Top module: `gpio_pcw_bank`

## Requirements
- R1: After reset every control field, every status bit, every debounce time word, `pin_out`, `pin_oe`, `irq` and `bus_rdata` are 0.
- R2: Pin n's control word sits at byte offset 0x180 + 4*n. Its bits are: 0 output level, 1 drive enable, 2 interrupt enable, 3/4/5 trigger bits t0/t1/t2, 6 reset tolerance, 7/8 debounce selects, 9 input mask, 12 interrupt status, 13 sampled input. Bits 10 and 11 are accepted but read 0. Read data appears on `bus_rdata` the cycle after the request and is 0 in every cycle without a valid read.
- R3: A control word write with any of bits 14..31 set changes no field and clears no status.
- R4: The stored drive enable is (written | ~input_capable) & output_capable. An input-only pin reads 0, an output-only pin reads 1 and an absent pin reads 0.
- R5: The stored output level is ANDed with output_capable. The stored input mask is ANDed with input_capable.
- R6: Writing 1 to bit 12 clears that pin's status, whether or not it was set. Writing 0 leaves it unchanged. An event in the same cycle wins over the clear.
- R7: With t1=0 and t2=0, t0=1 selects rising edges and t0=0 selects falling edges. A pin change driven before clock edge k sets the status after edge k+2 (two synchronizer stages, then the detector).
- R8: With t1=1, t0=1 selects high level and t0=0 selects low level, and the status is set again on every cycle the level holds. With t1=0 and t2=1, both edges are detected.
- R9: While the input mask is 1, the sampled input bit stays frozen and no event is raised. After unmasking, a difference between the frozen bit and the pin is treated as an edge.
- R10: Status is set only when interrupt enable is 1. `irq` is the OR over pins of status AND enable, so clearing enable drops `irq` but keeps the status bit.
- R11: The summary word at 0x100 + 4*s holds the status of pins 32*s..32*s+31 in bits 0..31. It is read-only.
- R12: The three debounce time words at 0x000, 0x004 and 0x008 are fully readable and writable.
- R13: An access without all four byte enables, an unaligned address, an unmapped offset or a pin at or beyond the pin count reads 0, and a write there changes nothing.
- R14: `pin_out` carries each pin's stored output level and `pin_oe` carries its stored drive enable (1 = drive).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_sel | input | 1 | Access request this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_be | input | 4 | Byte enables; only 4'hF is a valid access |
| bus_addr | input | 12 | Byte offset in the 4 KiB window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, one cycle after the request |
| pin_in | input | NUM_PINS | External pin levels (asynchronous) |
| pin_out | output | NUM_PINS | Driven level per pin |
| pin_oe | output | NUM_PINS | Drive enable per pin |
| irq | output | 1 | Combined interrupt |

## Verification
Register writes take effect in the cycle after the request. Read data is registered, so it is sampled on the falling edge after the request's rising edge. A pin change made on a falling edge reaches the status bit and `irq` after the third rising edge that follows. The directed checks sample `irq` on each of those three falling edges. Every other read is taken after at least four idle cycles. A behavioural model runs alongside the design, with the same two-stage pipeline and decode rules, and it is compared on every falling edge against `pin_out`, `pin_oe`, `irq` and `bus_rdata`.

// File: rtl/gpio_pcw_pkg.sv
package gpio_pcw_pkg;

  localparam int ADDR_W = 12;
  localparam int WIDX_W = ADDR_W - 2;
  localparam int MAX_PINS = 216;

  // control word bit positions (software visible)
  localparam int CW_OUT    = 0;
  localparam int CW_DIR    = 1;
  localparam int CW_IEN    = 2;
  localparam int CW_T0     = 3;
  localparam int CW_T2     = 5;
  localparam int CW_RTOL   = 6;
  localparam int CW_DB1    = 7;
  localparam int CW_DB2    = 8;
  localparam int CW_MASK   = 9;
  localparam int CW_STAT   = 12;
  localparam int CW_IN     = 13;
  localparam int CW_RSV_LO = 14;

  // word-index bases of the three regions
  localparam int DEB_COUNT = 3;
  localparam logic [WIDX_W-1:0] SUM_W0 = 10'h040;
  localparam logic [WIDX_W-1:0] PIN_W0 = 10'h060;

  typedef struct packed {
    logic       mask;
    logic       db2;
    logic       db1;
    logic       rtol;
    logic [2:0] trig;
    logic       ien;
    logic       dir;
    logic       dout;
  } pin_ctrl_t;

  // apply the pin's capabilities to a written word
  function automatic pin_ctrl_t capped_ctrl(logic [CW_IN:0] w, logic can_in, logic can_out);
    pin_ctrl_t c;
    c.dout = w[CW_OUT] & can_out;
    c.dir  = (w[CW_DIR] | ~can_in) & can_out;
    c.ien  = w[CW_IEN];
    c.trig = w[CW_T2:CW_T0];
    c.rtol = w[CW_RTOL];
    c.db1  = w[CW_DB1];
    c.db2  = w[CW_DB2];
    c.mask = w[CW_MASK] & can_in;
    return c;
  endfunction

  // trigger decode: t1 picks level, else t2 picks both edges, else t0 picks polarity
  function automatic logic trig_hit(logic [2:0] trig, logic prev, logic cur);
    if (trig[1])      return trig[0] ? cur : ~cur;
    else if (trig[2]) return prev ^ cur;
    else              return trig[0] ? (~prev & cur) : (prev & ~cur);
  endfunction

  function automatic logic [31:0] pack_word(pin_ctrl_t c, logic st, logic lvl);
    logic [31:0] w;
    w = '0;
    w[CW_OUT]        = c.dout;
    w[CW_DIR]        = c.dir;
    w[CW_IEN]        = c.ien;
    w[CW_T2:CW_T0]   = c.trig;
    w[CW_RTOL]       = c.rtol;
    w[CW_DB1]        = c.db1;
    w[CW_DB2]        = c.db2;
    w[CW_MASK]       = c.mask;
    w[CW_STAT]       = st;
    w[CW_IN]         = lvl;
    return w;
  endfunction

endpackage

// File: rtl/gpio_pcw_insync.sv
module gpio_pcw_insync #(
  parameter int WIDTH  = 8,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [STAGES-1:0][WIDTH-1:0] pipe;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pipe <= '0;
    end else begin
      pipe[0] <= d;
      for (int i = 1; i < STAGES; i++) pipe[i] <= pipe[i-1];
    end
  end

  assign q = pipe[STAGES-1];
endmodule

// File: rtl/gpio_pcw_pin.sv
module gpio_pcw_pin
  import gpio_pcw_pkg::*;
#(
  parameter logic CAN_IN  = 1'b1,
  parameter logic CAN_OUT = 1'b1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [CW_IN:0]  wr_bits,
  input  logic            sync_in,
  output logic [31:0]     word,
  output logic            drv_out,
  output logic            drv_oe,
  output logic            int_en,
  output logic            in_mask,
  output logic            int_stat,
  output logic            in_level,
  output logic            ev_set,
  output logic            ev_clr
);
  pin_ctrl_t ctrl_q;
  logic      stat_q;
  logic      lvl_q;

  always_comb begin
    ev_set = ~ctrl_q.mask & ctrl_q.ien & trig_hit(ctrl_q.trig, lvl_q, sync_in);
    ev_clr = wr_en & wr_bits[CW_STAT];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      stat_q <= 1'b0;
      lvl_q  <= 1'b0;
    end else begin
      if (wr_en) ctrl_q <= capped_ctrl(wr_bits, CAN_IN, CAN_OUT);
      if (ev_set)      stat_q <= 1'b1;
      else if (ev_clr) stat_q <= 1'b0;
      if (!ctrl_q.mask) lvl_q <= sync_in;
    end
  end

  assign word     = pack_word(ctrl_q, stat_q, lvl_q);
  assign drv_out  = ctrl_q.dout;
  assign drv_oe   = ctrl_q.dir;
  assign int_en   = ctrl_q.ien;
  assign in_mask  = ctrl_q.mask;
  assign int_stat = stat_q;
  assign in_level = lvl_q;
endmodule

// File: rtl/gpio_pcw_regif.sv
module gpio_pcw_regif
  import gpio_pcw_pkg::*;
#(
  parameter int NUM_PINS = 40,
  parameter int NUM_SETS = 2
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          bus_sel,
  input  logic                          bus_we,
  input  logic [3:0]                    bus_be,
  input  logic [ADDR_W-1:0]             bus_addr,
  input  logic [31:0]                   bus_wdata,
  output logic [31:0]                   bus_rdata,
  input  logic [NUM_PINS-1:0][31:0]     pin_words,
  input  logic [NUM_SETS-1:0][31:0]     sum_words,
  output logic [NUM_PINS-1:0]           pin_wr
);
  logic [WIDX_W-1:0] widx, sum_off, pin_off;
  logic              acc_ok, deb_hit, sum_hit, pin_hit, pin_wr_ok;
  logic [DEB_COUNT-1:0][31:0] deb_q;
  logic [31:0]       rd_val;

  always_comb begin
    widx    = bus_addr[ADDR_W-1:2];
    acc_ok  = bus_sel && (bus_be == 4'hF) && (bus_addr[1:0] == 2'b00);
    sum_off = widx - SUM_W0;
    pin_off = widx - PIN_W0;
    deb_hit = widx < WIDX_W'(DEB_COUNT);
    sum_hit = (widx >= SUM_W0) && (sum_off < WIDX_W'(NUM_SETS));
    pin_hit = (widx >= PIN_W0) && (pin_off < WIDX_W'(NUM_PINS));
    pin_wr_ok = acc_ok && bus_we && pin_hit && (bus_wdata[31:CW_RSV_LO] == '0);
  end

  for (genvar g = 0; g < NUM_PINS; g++) begin : g_wr
    assign pin_wr[g] = pin_wr_ok && (pin_off == WIDX_W'(g));
  end

  for (genvar j = 0; j < DEB_COUNT; j++) begin : g_deb
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) deb_q[j] <= '0;
      else if (acc_ok && bus_we && (widx == WIDX_W'(j))) deb_q[j] <= bus_wdata;
    end
  end

  always_comb begin
    rd_val = '0;
    if (deb_hit) begin
      for (int j = 0; j < DEB_COUNT; j++)
        if (widx == WIDX_W'(j)) rd_val = deb_q[j];
    end else if (sum_hit) begin
      for (int s = 0; s < NUM_SETS; s++)
        if (sum_off == WIDX_W'(s)) rd_val = sum_words[s];
    end else if (pin_hit) begin
      for (int n = 0; n < NUM_PINS; n++)
        if (pin_off == WIDX_W'(n)) rd_val = pin_words[n];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bus_rdata <= '0;
    else        bus_rdata <= (acc_ok && !bus_we) ? rd_val : '0;
  end
endmodule

// File: rtl/gpio_pcw_bank.sv
module gpio_pcw_bank
  import gpio_pcw_pkg::*;
#(
  parameter int                NUM_PINS    = 40,
  parameter int                SYNC_STAGES = 2,
  parameter logic [NUM_PINS-1:0] IN_CAP    = 40'h9F_FFFF_FFFF,
  parameter logic [NUM_PINS-1:0] OUT_CAP   = 40'hAF_FFFF_FFFF
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bus_sel,
  input  logic                bus_we,
  input  logic [3:0]          bus_be,
  input  logic [11:0]         bus_addr,
  input  logic [31:0]         bus_wdata,
  output logic [31:0]         bus_rdata,
  input  logic [NUM_PINS-1:0] pin_in,
  output logic [NUM_PINS-1:0] pin_out,
  output logic [NUM_PINS-1:0] pin_oe,
  output logic                irq
);
  localparam int NUM_SETS = (NUM_PINS + 31) / 32;
  localparam int SUM_BITS = NUM_SETS * 32;

  logic [NUM_PINS-1:0]       sync_vec;
  logic [NUM_PINS-1:0][31:0] pin_words;
  logic [NUM_PINS-1:0]       pin_wr;
  logic [NUM_PINS-1:0]       status_vec, enable_vec, mask_vec, in_data_vec;
  logic [NUM_PINS-1:0]       set_vec, clr_vec;
  logic [SUM_BITS-1:0]       sum_flat;
  logic [NUM_SETS-1:0][31:0] sum_words;

  gpio_pcw_insync #(.WIDTH(NUM_PINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(pin_in), .q(sync_vec)
  );

  for (genvar g = 0; g < NUM_PINS; g++) begin : g_pin
    gpio_pcw_pin #(.CAN_IN(IN_CAP[g]), .CAN_OUT(OUT_CAP[g])) u_pin (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (pin_wr[g]),
      .wr_bits  (bus_wdata[CW_IN:0]),
      .sync_in  (sync_vec[g]),
      .word     (pin_words[g]),
      .drv_out  (pin_out[g]),
      .drv_oe   (pin_oe[g]),
      .int_en   (enable_vec[g]),
      .in_mask  (mask_vec[g]),
      .int_stat (status_vec[g]),
      .in_level (in_data_vec[g]),
      .ev_set   (set_vec[g]),
      .ev_clr   (clr_vec[g])
    );
  end

  assign sum_flat  = SUM_BITS'(status_vec);
  assign sum_words = sum_flat;

  gpio_pcw_regif #(.NUM_PINS(NUM_PINS), .NUM_SETS(NUM_SETS)) u_regif (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_sel   (bus_sel),
    .bus_we    (bus_we),
    .bus_be    (bus_be),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .pin_words (pin_words),
    .sum_words (sum_words),
    .pin_wr    (pin_wr)
  );

  assign irq = |(status_vec & enable_vec);
endmodule

// File: rtl/gpio_pcw_checker.sv
module gpio_pcw_checker #(
  parameter int NUM_PINS = 40
) (
  input logic                clk,
  input logic                rst_n,
  input logic                bus_sel,
  input logic                bus_we,
  input logic [3:0]          bus_be,
  input logic [1:0]          addr_lo,
  input logic [17:0]         rsv_bits,
  input logic [31:0]         bus_rdata,
  input logic [NUM_PINS-1:0] pin_out,
  input logic [NUM_PINS-1:0] pin_oe,
  input logic [NUM_PINS-1:0] status_vec,
  input logic [NUM_PINS-1:0] enable_vec,
  input logic [NUM_PINS-1:0] mask_vec,
  input logic [NUM_PINS-1:0] in_data_vec,
  input logic [NUM_PINS-1:0] set_vec,
  input logic [NUM_PINS-1:0] clr_vec
);
  AST_BAD_ACCESS_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && !bus_we && (bus_be != 4'hF || addr_lo != 2'b00)) |=> (bus_rdata == '0)); // R13

  AST_RESERVED_WRITE_REJECTED: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_we && rsv_bits != '0) |=>
      ($stable(pin_out) && $stable(pin_oe) && $stable(enable_vec) && $stable(mask_vec))); // R3

  AST_STATUS_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((status_vec & ~$past(status_vec) & ~$past(enable_vec)) == '0)); // R10

  AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(clr_vec & ~set_vec) & status_vec) == '0)); // R6

  AST_MASK_FREEZES: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (((in_data_vec ^ $past(in_data_vec)) & $past(mask_vec)) == '0)); // R9
endmodule

bind gpio_pcw_bank gpio_pcw_checker #(.NUM_PINS(NUM_PINS)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .bus_sel     (bus_sel),
  .bus_we      (bus_we),
  .bus_be      (bus_be),
  .addr_lo     (bus_addr[1:0]),
  .rsv_bits    (bus_wdata[31:14]),
  .bus_rdata   (bus_rdata),
  .pin_out     (pin_out),
  .pin_oe      (pin_oe),
  .status_vec  (status_vec),
  .enable_vec  (enable_vec),
  .mask_vec    (mask_vec),
  .in_data_vec (in_data_vec),
  .set_vec     (set_vec),
  .clr_vec     (clr_vec)
);

// File: tb/test_gpio_pcw_bank.sv
module test_gpio_pcw_bank;
  localparam int NP = 40;
  localparam int NSETS = 2;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic          rst_n = 1'b0;
  logic          bus_sel = 1'b0, bus_we = 1'b0;
  logic [3:0]    bus_be = 4'hF;
  logic [11:0]   bus_addr = '0;
  logic [31:0]   bus_wdata = '0;
  logic [31:0]   bus_rdata;
  logic [NP-1:0] pin_in = '0;
  logic [NP-1:0] pin_out, pin_oe;
  logic          irq;

  gpio_pcw_bank i_gpio_pcw_bank (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we), .bus_be(bus_be),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq)
  );

  int n_chk = 0;
  int n_fail = 0;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // capabilities: 36 input-only, 37 output-only, 38 absent
  function automatic bit can_in(int p);  return !(p == 37 || p == 38); endfunction
  function automatic bit can_out(int p); return !(p == 36 || p == 38); endfunction

  // ---------------- behavioural reference model ----------------
  logic [NP-1:0] m_dout, m_dir, m_ien, m_t0, m_t1, m_t2, m_rtol, m_db1, m_db2, m_mask;
  logic [NP-1:0] m_stat, m_lvl, m_q1, m_q2;
  logic [31:0]   m_deb [3];
  logic [31:0]   m_rdata;

  function automatic logic [31:0] m_word(int p);
    return {18'b0, m_lvl[p], m_stat[p], 2'b00, m_mask[p], m_db2[p], m_db1[p], m_rtol[p],
            m_t2[p], m_t1[p], m_t0[p], m_ien[p], m_dir[p], m_dout[p]};
  endfunction

  function automatic logic [31:0] m_read(int a);
    logic [31:0] v;
    v = '0;
    if (a < 12) v = m_deb[a/4];
    else if (a >= 'h100 && a < 'h100 + 4*NSETS) begin
      for (int b = 0; b < 32; b++) begin
        int p;
        p = ((a - 'h100) / 4) * 32 + b;
        if (p < NP) v[b] = m_stat[p];
      end
    end else if (a >= 'h180 && (a - 'h180) / 4 < NP) v = m_word((a - 'h180) / 4);
    return v;
  endfunction

  function automatic bit m_fires(bit t2, bit t1, bit t0, bit prev, bit cur);
    if (t1) return t0 ? cur : !cur;
    if (t2) return prev != cur;
    if (t0) return !prev && cur;
    return prev && !cur;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_dout = '0; m_dir = '0; m_ien = '0; m_t0 = '0; m_t1 = '0; m_t2 = '0;
      m_rtol = '0; m_db1 = '0; m_db2 = '0; m_mask = '0; m_stat = '0; m_lvl = '0;
      m_q1 = '0; m_q2 = '0; m_rdata = '0;
      for (int i = 0; i < 3; i++) m_deb[i] = '0;
    end else begin
      int  a;
      int  widx;
      bit  ok, wr_hit;
      logic [NP-1:0] setv;
      a = int'(bus_addr);
      ok = bus_sel && bus_be == 4'hF && (a % 4) == 0;
      m_rdata = (ok && !bus_we) ? m_read(a) : 32'h0;
      widx = (a - 'h180) / 4;
      wr_hit = ok && bus_we && a >= 'h180 && widx < NP && bus_wdata[31:14] == 0;
      for (int p = 0; p < NP; p++)
        setv[p] = !m_mask[p] && m_ien[p] && m_fires(m_t2[p], m_t1[p], m_t0[p], m_lvl[p], m_q2[p]);
      for (int p = 0; p < NP; p++) begin
        if (setv[p]) m_stat[p] = 1'b1;
        else if (wr_hit && widx == p && bus_wdata[12]) m_stat[p] = 1'b0;
        if (!m_mask[p]) m_lvl[p] = m_q2[p];
      end
      if (ok && bus_we && a < 12) m_deb[a/4] = bus_wdata;
      if (wr_hit) begin
        m_dout[widx] = bus_wdata[0] & can_out(widx);
        m_dir[widx]  = (bus_wdata[1] | !can_in(widx)) & can_out(widx);
        m_ien[widx]  = bus_wdata[2];
        m_t0[widx]   = bus_wdata[3];
        m_t1[widx]   = bus_wdata[4];
        m_t2[widx]   = bus_wdata[5];
        m_rtol[widx] = bus_wdata[6];
        m_db1[widx]  = bus_wdata[7];
        m_db2[widx]  = bus_wdata[8];
        m_mask[widx] = bus_wdata[9] & can_in(widx);
      end
      m_q2 = m_q1;
      m_q1 = pin_in;
    end
  end

  // model comparison on every clock
  always @(negedge clk) begin
    chk("R14 pin_out vs model", 64'(pin_out), 64'(m_dout));
    chk("R14 pin_oe vs model",  64'(pin_oe),  64'(m_dir));
    chk("R10 irq vs model",     64'(irq),     64'(|(m_stat & m_ien)));
    chk("R2 rdata vs model",    64'(bus_rdata), 64'(m_rdata));
  end

  // ---------------- bus tasks ----------------
  function automatic logic [11:0] pa(int p); return 12'(12'h180 + 4*p); endfunction

  task automatic wr(input logic [11:0] a, input logic [31:0] d, input logic [3:0] be = 4'hF);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d; bus_be = be;
    @(negedge clk);
    bus_sel = 1'b0; bus_we = 1'b0; bus_be = 4'hF;
  endtask

  task automatic rdchk(input string tag, input logic [11:0] a, input logic [31:0] exp,
                       input logic [3:0] be = 4'hF);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a; bus_be = be;
    @(negedge clk);
    chk(tag, 64'(bus_rdata), 64'(exp));
    bus_sel = 1'b0; bus_be = 4'hF;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  // ---------------- directed sequence ----------------
  initial begin
    idle(5);
    rst_n = 1'b1;
    idle(2);
    // R1 reset state
    chk("R1 pin_oe after reset", 64'(pin_oe), 64'h0);
    chk("R1 pin_out after reset", 64'(pin_out), 64'h0);
    chk("R1 irq after reset", 64'(irq), 64'h0);
    rdchk("R1 pin0 word", pa(0), 32'h0);
    rdchk("R1 pin39 word", pa(39), 32'h0);
    rdchk("R1 debounce0", 12'h000, 32'h0);

    // R2 layout and readback, R14 pins
    wr(pa(5), 32'h0000_0FFF);
    rdchk("R2 pin5 full word, blink bits read 0", pa(5), 32'h0000_03FF);
    chk("R14 pin_out[5]", 64'(pin_out[5]), 64'h1);
    chk("R14 pin_oe[5]", 64'(pin_oe[5]), 64'h1);
    wr(pa(5), 32'h0);
    rdchk("R2 pin5 cleared", pa(5), 32'h0);

    // R3 reserved bits
    wr(pa(6), 32'h0000_0003);
    wr(pa(6), 32'h0001_0000);
    rdchk("R3 reserved write ignored", pa(6), 32'h0000_0003);

    // R4 direction forcing
    wr(pa(36), 32'h2);
    rdchk("R4 input-only dir reads 0", pa(36), 32'h0);
    wr(pa(37), 32'h0);
    rdchk("R4 output-only dir reads 1", pa(37), 32'h2);
    wr(pa(38), 32'h3);
    rdchk("R4 absent pin reads 0", pa(38), 32'h0);

    // R5 output and mask capability
    wr(pa(36), 32'h201);
    rdchk("R5 input-only keeps mask, drops out", pa(36), 32'h200);
    wr(pa(37), 32'h201);
    rdchk("R5 output-only keeps out, drops mask", pa(37), 32'h3);
    wr(pa(36), 32'h0);

    // R7 rising edge with exact latency
    wr(pa(10), 32'h0C);
    @(negedge clk); pin_in[10] = 1'b1;
    @(negedge clk); chk("R7 irq low after edge k", 64'(irq), 64'h0);
    @(negedge clk); chk("R7 irq low after edge k+1", 64'(irq), 64'h0);
    @(negedge clk); chk("R7 irq high after edge k+2", 64'(irq), 64'h1);
    rdchk("R7 rising status and input", pa(10), 32'h300C);
    // R7 falling edge
    wr(pa(11), 32'h04);
    pin_in[11] = 1'b1; idle(4);
    rdchk("R7 rise ignored by falling trigger", pa(11), 32'h2004);
    pin_in[11] = 1'b0; idle(4);
    rdchk("R7 falling status", pa(11), 32'h1004);

    // R6 write-one-to-clear
    wr(pa(10), 32'h0C);
    rdchk("R6 write 0 keeps status", pa(10), 32'h300C);
    wr(pa(10), 32'h100C);
    rdchk("R6 write 1 clears status", pa(10), 32'h200C);
    wr(pa(12), 32'h1000);
    rdchk("R6 clear of idle status harmless", pa(12), 32'h0);
    wr(pa(10), 32'h1000);
    wr(pa(11), 32'h1000);

    // R8 level and both edges
    wr(pa(13), 32'h1C);
    pin_in[13] = 1'b1; idle(4);
    wr(pa(13), 32'h101C);
    rdchk("R8 high level re-sets over clear", pa(13), 32'h301C);
    pin_in[13] = 1'b0; idle(4);
    wr(pa(13), 32'h101C);
    rdchk("R8 level gone, clear holds", pa(13), 32'h001C);
    wr(pa(13), 32'h1000);
    wr(pa(14), 32'h24);
    pin_in[14] = 1'b1; idle(4);
    rdchk("R8 both-edge rise", pa(14), 32'h3024);
    wr(pa(14), 32'h1024);
    rdchk("R8 both-edge cleared", pa(14), 32'h2024);
    pin_in[14] = 1'b0; idle(4);
    rdchk("R8 both-edge fall", pa(14), 32'h1024);
    wr(pa(14), 32'h1000);

    // R9 input mask
    wr(pa(15), 32'h20C);
    pin_in[15] = 1'b1; idle(4);
    rdchk("R9 masked input frozen, no event", pa(15), 32'h020C);
    wr(pa(15), 32'h0C); idle(4);
    rdchk("R9 unmask sees edge", pa(15), 32'h300C);
    wr(pa(15), 32'h1000);

    // R10 enable gating and irq
    wr(pa(16), 32'h08);
    pin_in[16] = 1'b1; idle(4);
    rdchk("R10 no status without enable", pa(16), 32'h2008);
    chk("R10 irq low", 64'(irq), 64'h0);
    wr(pa(17), 32'h0C);
    pin_in[17] = 1'b1; idle(4);
    chk("R10 irq high", 64'(irq), 64'h1);
    wr(pa(17), 32'h08);
    chk("R10 irq drops with enable", 64'(irq), 64'h0);
    rdchk("R10 status kept", pa(17), 32'h3008);

    // R11 summary words
    wr(pa(33), 32'h0C);
    pin_in[33] = 1'b1; idle(4);
    rdchk("R11 summary set0", 12'h100, 32'h0002_0000);
    rdchk("R11 summary set1", 12'h104, 32'h0000_0002);
    wr(12'h104, 32'h0);
    rdchk("R11 summary read-only", 12'h104, 32'h0000_0002);
    rdchk("R13 summary beyond sets", 12'h108, 32'h0);

    // R12 debounce time words
    wr(12'h000, 32'hDEAD_BEEF);
    wr(12'h008, 32'h1234_5678);
    rdchk("R12 debounce0", 12'h000, 32'hDEAD_BEEF);
    rdchk("R12 debounce2", 12'h008, 32'h1234_5678);
    rdchk("R12 debounce1 untouched", 12'h004, 32'h0);

    // R13 invalid accesses
    rdchk("R13 partial read", 12'h000, 32'h0, 4'h3);
    wr(12'h004, 32'hFF, 4'h1);
    rdchk("R13 partial write ignored", 12'h004, 32'h0);
    wr(12'h182, 32'h3);
    rdchk("R13 unaligned write ignored", pa(0), 32'h0);
    wr(pa(NP), 32'h3);
    rdchk("R13 pin beyond count", pa(NP), 32'h0);
    rdchk("R13 unmapped offset", 12'h010, 32'h0);

    idle(3);
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule